// File: doc/BRIEF.md
# Pin-Change GPIO Bank

This block is a bank of general-purpose pins with a word-wide register bus. Software sets each pin as an input or an output, writes the levels that output pins drive, and reads back a data word. It also keeps an open-drain setting per pin, which the block stores and passes to the pad ring. Input pins pass through a two-stage synchronizer. Their sampled level is written into the data word. A level change on an input pin can latch a per-pin event flag. Each pin is set for one of two capture modes: any change, or a high-to-low change only.

A single level interrupt is raised while any event flag is set whose mask bit is also set. Software clears event flags by writing ones to them. The bus is honoured only for full-word accesses. A narrower access changes nothing, and a narrower read returns zero. Register bits are numbered against the pins: pin n lives in register bit 31-n.

Top module: `gpio_pinbank`

## Requirements
- R1: Registers sit at byte offsets 0x00 direction, 0x04 open-drain, 0x08 data, 0x0C event, 0x10 mask and 0x14 capture-mode. Every other offset, including misaligned ones such as 0x02 or 0x18, reads as zero, and a write to it changes no register.
- R2: Pin n (port bit n of pin_in, pin_out, pin_oe and pin_od) corresponds to register bit 31-n. Pin 0 is register bit 31.
- R3: A direction bit of 1 makes the pin an output: pin_oe is high, and pin_out carries the data bit. A direction bit of 0 makes the pin an input: pin_oe and pin_out are low for it. The data bit of an input pin still stores a written value, and that value reads back.
- R4: A write to the event register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: irq is high exactly when the event and mask registers share a set bit. It follows a register write or a latched event in the next cycle.
- R6: For an input pin whose capture-mode bit is 0, a rising or a falling level latches its event bit, and the data bit takes the new level. This happens at the third rising clock edge after the pin changes: two synchronizer stages, then the capture stage.
- R7: For an input pin whose capture-mode bit is 1, only a high-to-low change latches the event bit. A rising level still updates the data bit.
- R8: Level changes on a pin set as an output change neither its data bit nor its event bit.
- R9: An access with any byte-enable bit low is dropped. A write changes nothing, and a read returns zero.
- R10: Reset clears all six registers, so all pins are inputs, irq is low, and pin_out, pin_oe and pin_od are low.
- R11: An event that is latched in the same cycle as a write of 1 that would clear the same bit takes priority, and the bit stays set.
- R12: Each read request (bus_sel high, bus_wr low) produces bus_rvalid high one cycle later, with bus_rdata valid in that same cycle.
- R13: pin_od presents the open-drain register, in pin order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_be | input | 4 | Byte enables; all must be set for the access to count |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe, one cycle after the request |
| pin_in | input | 32 | Pad input levels, indexed by pin number |
| pin_out | output | 32 | Output levels, indexed by pin number |
| pin_oe | output | 32 | Output enables, indexed by pin number |
| pin_od | output | 32 | Open-drain settings, indexed by pin number |
| irq | output | 1 | Level interrupt |

## Verification
A bad event register shows on irq in the cycle after the fault once the matching mask bit is set, and on the next read of offset 0x0C otherwise. A bad direction or data bit shows on pin_oe or pin_out in the cycle after the write that caused it. A lost or spurious edge becomes visible at the capture edge, three clocks after the pad moves. The bench therefore reads back exactly at that boundary. It also puts a pin change and a clear write on the same edge, so that a wrong priority between them is exposed at once.

// File: rtl/gpio_pb_pkg.sv
package gpio_pb_pkg;

  localparam int unsigned OFF_DIR  = 'h00;
  localparam int unsigned OFF_OD   = 'h04;
  localparam int unsigned OFF_DATA = 'h08;
  localparam int unsigned OFF_EVT  = 'h0C;
  localparam int unsigned OFF_MASK = 'h10;
  localparam int unsigned OFF_CTL  = 'h14;

  typedef enum logic [2:0] {
    SEL_DIR,
    SEL_OD,
    SEL_DATA,
    SEL_EVT,
    SEL_MASK,
    SEL_CTL,
    SEL_NONE
  } reg_sel_e;

endpackage

// File: rtl/gpio_pb_sync.sv
module gpio_pb_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] prev_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stg_d;
      if (s == 0) begin : g_first
        assign stg_d = async_i;
      end else begin : g_next
        assign stg_d = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_d;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stg_q[LAST];
  end

  assign lvl_o  = stg_q[LAST];
  assign prev_o = prev_q;

endmodule

// File: rtl/gpio_pb_evdet.sv
module gpio_pb_evdet #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] fall_only_i,
  output logic [W-1:0] chg_o,
  output logic [W-1:0] ev_set_o
);

  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      logic is_in;
      logic moved;
      logic fell;
      always_comb begin
        is_in       = ~dir_i[b];
        moved       = lvl_i[b] ^ prev_i[b];
        fell        = prev_i[b] & ~lvl_i[b];
        chg_o[b]    = is_in & moved;
        ev_set_o[b] = is_in & (fall_only_i[b] ? fell : moved);
      end
    end
  endgenerate

endmodule

// File: rtl/gpio_pb_regs.sv
module gpio_pb_regs
  import gpio_pb_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W/8-1:0] bus_be,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          bus_rvalid,
  input  logic [W-1:0]  lvl_i,
  input  logic [W-1:0]  chg_i,
  input  logic [W-1:0]  ev_set_i,
  output logic [W-1:0]  dir_o,
  output logic [W-1:0]  od_o,
  output logic [W-1:0]  dat_o,
  output logic [W-1:0]  ev_o,
  output logic [W-1:0]  mask_o,
  output logic [W-1:0]  ctl_o
);

  localparam int unsigned BEW = W / 8;

  reg_sel_e     sel;
  logic         full;
  logic         wr_ok;
  logic         rd_req;
  logic         rd_ok;

  logic [W-1:0] dir_q,  dir_d;
  logic [W-1:0] od_q,   od_d;
  logic [W-1:0] dat_q,  dat_d;
  logic [W-1:0] ev_q,   ev_d;
  logic [W-1:0] mask_q, mask_d;
  logic [W-1:0] ctl_q,  ctl_d;
  logic [W-1:0] rdata_q, rdata_d;
  logic         rvalid_q;
  logic         cfg_en;
  logic         dat_en;
  logic         ev_en;

  // address decode
  always_comb begin
    if      (bus_addr == AW'(OFF_DIR))  sel = SEL_DIR;
    else if (bus_addr == AW'(OFF_OD))   sel = SEL_OD;
    else if (bus_addr == AW'(OFF_DATA)) sel = SEL_DATA;
    else if (bus_addr == AW'(OFF_EVT))  sel = SEL_EVT;
    else if (bus_addr == AW'(OFF_MASK)) sel = SEL_MASK;
    else if (bus_addr == AW'(OFF_CTL))  sel = SEL_CTL;
    else                                sel = SEL_NONE;
  end

  assign full   = (bus_be == {BEW{1'b1}});
  assign wr_ok  = bus_sel & bus_wr & full;
  assign rd_req = bus_sel & ~bus_wr;
  assign rd_ok  = rd_req & full;

  // next state: configuration words
  always_comb begin
    dir_d  = dir_q;
    od_d   = od_q;
    mask_d = mask_q;
    ctl_d  = ctl_q;
    if (wr_ok) begin
      unique case (sel)
        SEL_DIR:  dir_d  = bus_wdata;
        SEL_OD:   od_d   = bus_wdata;
        SEL_MASK: mask_d = bus_wdata;
        SEL_CTL:  ctl_d  = bus_wdata;
        default: ;
      endcase
    end
  end

  assign cfg_en = wr_ok & (sel inside {SEL_DIR, SEL_OD, SEL_MASK, SEL_CTL});

  // next state: data word, sampled input change overrides a write
  always_comb begin
    dat_d = dat_q;
    if (wr_ok && sel == SEL_DATA) dat_d = bus_wdata;
    dat_d = (dat_d & ~chg_i) | (lvl_i & chg_i);
  end

  assign dat_en = (wr_ok && sel == SEL_DATA) || (|chg_i);

  // next state: event word, set beats clear
  always_comb begin
    logic [W-1:0] clr;
    clr  = (wr_ok && sel == SEL_EVT) ? bus_wdata : '0;
    ev_d = (ev_q & ~clr) | ev_set_i;
  end

  assign ev_en = (wr_ok && sel == SEL_EVT) || (|ev_set_i);

  // read mux
  always_comb begin
    rdata_d = '0;
    if (rd_ok) begin
      unique case (sel)
        SEL_DIR:  rdata_d = dir_q;
        SEL_OD:   rdata_d = od_q;
        SEL_DATA: rdata_d = dat_q;
        SEL_EVT:  rdata_d = ev_q;
        SEL_MASK: rdata_d = mask_q;
        SEL_CTL:  rdata_d = ctl_q;
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      od_q   <= '0;
      mask_q <= '0;
      ctl_q  <= '0;
    end else if (cfg_en) begin
      dir_q  <= dir_d;
      od_q   <= od_d;
      mask_q <= mask_d;
      ctl_q  <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dat_q <= '0;
    else if (dat_en) dat_q <= dat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ev_q <= '0;
    else if (ev_en) ev_q <= ev_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= rd_req;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign dir_o      = dir_q;
  assign od_o       = od_q;
  assign dat_o      = dat_q;
  assign ev_o       = ev_q;
  assign mask_o     = mask_q;
  assign ctl_o      = ctl_q;

endmodule

// File: rtl/gpio_pinbank.sv
module gpio_pinbank #(
  parameter int unsigned W           = 32,
  parameter int unsigned AW          = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [W/8-1:0] bus_be,
  input  logic [W-1:0]   bus_wdata,
  output logic [W-1:0]   bus_rdata,
  output logic           bus_rvalid,
  input  logic [W-1:0]   pin_in,
  output logic [W-1:0]   pin_out,
  output logic [W-1:0]   pin_oe,
  output logic [W-1:0]   pin_od,
  output logic           irq
);

  logic [W-1:0] in_bits;
  logic [W-1:0] lvl;
  logic [W-1:0] prev;
  logic [W-1:0] chg;
  logic [W-1:0] ev_set;
  logic [W-1:0] dir_q;
  logic [W-1:0] od_q;
  logic [W-1:0] dat_q;
  logic [W-1:0] ev_q;
  logic [W-1:0] mask_q;
  logic [W-1:0] ctl_q;

  // pin n <-> register bit W-1-n
  generate
    for (genvar n = 0; n < W; n++) begin : g_pin
      assign in_bits[W-1-n] = pin_in[n];
      assign pin_oe[n]      = dir_q[W-1-n];
      assign pin_out[n]     = dir_q[W-1-n] & dat_q[W-1-n];
      assign pin_od[n]      = od_q[W-1-n];
    end
  endgenerate

  gpio_pb_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(in_bits),
    .lvl_o  (lvl),
    .prev_o (prev)
  );

  gpio_pb_evdet #(.W(W)) u_evdet (
    .lvl_i      (lvl),
    .prev_i     (prev),
    .dir_i      (dir_q),
    .fall_only_i(ctl_q),
    .chg_o      (chg),
    .ev_set_o   (ev_set)
  );

  gpio_pb_regs #(.W(W), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_rvalid(bus_rvalid),
    .lvl_i     (lvl),
    .chg_i     (chg),
    .ev_set_i  (ev_set),
    .dir_o     (dir_q),
    .od_o      (od_q),
    .dat_o     (dat_q),
    .ev_o      (ev_q),
    .mask_o    (mask_q),
    .ctl_o     (ctl_q)
  );

  assign irq = |(ev_q & mask_q);

endmodule

// File: rtl/gpio_pb_chk.sv
module gpio_pb_chk
  import gpio_pb_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_sel,
  input logic           bus_wr,
  input logic [AW-1:0]  bus_addr,
  input logic [W/8-1:0] bus_be,
  input logic [W-1:0]   bus_wdata,
  input logic [W-1:0]   bus_rdata,
  input logic           bus_rvalid,
  input logic [W-1:0]   pin_out,
  input logic [W-1:0]   pin_oe,
  input logic           irq,
  input logic [W-1:0]   ev_set,
  input logic [W-1:0]   ev_q
);

  localparam int unsigned BEW = W / 8;

  logic full_wr;
  assign full_wr = bus_sel & bus_wr & (bus_be == {BEW{1'b1}});

  // R12: read response one cycle after each read request
  assert_rd_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> bus_rvalid);

  assert_no_stray_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> !bus_rvalid);

  // R9: narrow reads return zero
  assert_narrow_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_be != {BEW{1'b1}}) |=> (bus_rdata == '0));

  // R5: clearing the mask drops the interrupt
  assert_mask_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full_wr && bus_addr == AW'(OFF_MASK) && bus_wdata == '0) |=> !irq);

  // R8: pin outputs only move on a direction or data write
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_wr && (bus_addr == AW'(OFF_DATA) || bus_addr == AW'(OFF_DIR)))
      |=> ($stable(pin_out) && $stable(pin_oe)));

  // R4: a one written to the event word leaves the bit clear unless re-latched
  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full_wr && bus_addr == AW'(OFF_EVT))
      |=> ((ev_q & $past(bus_wdata) & ~$past(ev_set)) == '0));

  // R11: a latched event always lands, even against a clear
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_set) |=> ((ev_q & $past(ev_set)) == $past(ev_set)));

  // R10: outputs quiet while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R10: assert (!irq && pin_oe == '0 && pin_out == '0);
    end
  end

endmodule

bind gpio_pinbank gpio_pb_chk #(.W(W), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_rvalid(bus_rvalid),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .ev_set    (ev_set),
  .ev_q      (ev_q)
);

// File: tb/tb_gpio_pinbank.sv
`timescale 1ns/1ps
module tb_gpio_pinbank;

  localparam logic [11:0] A_DIR  = 12'h000;
  localparam logic [11:0] A_OD   = 12'h004;
  localparam logic [11:0] A_DATA = 12'h008;
  localparam logic [11:0] A_EVT  = 12'h00C;
  localparam logic [11:0] A_MASK = 12'h010;
  localparam logic [11:0] A_CTL  = 12'h014;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [11:0] bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic [31:0] pin_od;
  logic        irq;

  int total;
  int bad;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  gpio_pinbank dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_rvalid(bus_rvalid),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pin_od    (pin_od),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] rev(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // driver: push the expected read word, then issue the request
  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag,
                    input logic [3:0] be = 4'hF);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // monitor: pop and compare each read response
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R12: unexpected response %h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, bus_rdata, e);
      end
    end
  end

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_be = 4'hF; bus_wdata = '0; pin_in = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    chk("R10 irq", {31'd0, irq}, 32'd0);
    chk("R10 pin_oe", pin_oe, 32'd0);
    chk("R10 pin_out", pin_out, 32'd0);
    chk("R10 pin_od", pin_od, 32'd0);
    rd(A_DIR,  32'd0, "R10 dir");
    rd(A_OD,   32'd0, "R10 od");
    rd(A_DATA, 32'd0, "R10 data");
    rd(A_EVT,  32'd0, "R10 evt");
    rd(A_MASK, 32'd0, "R10 mask");
    rd(A_CTL,  32'd0, "R10 ctl");

    // R2 R3: direction and output driving
    wr(A_DIR, 32'h8000_0002);
    chk("R2 pin_oe order", pin_oe, rev(32'h8000_0002));
    wr(A_DATA, 32'hC000_0003);
    chk("R3 pin_out outputs only", pin_out, rev(32'h8000_0002));
    rd(A_DATA, 32'hC000_0003, "R3 input bits stored");

    // R13 R1: register map and unmapped offsets
    wr(A_OD, 32'h1234_5678);
    chk("R13 pin_od", pin_od, rev(32'h1234_5678));
    rd(A_OD, 32'h1234_5678, "R1 od readback");
    wr(A_MASK, 32'h0F0F_0000);
    rd(A_MASK, 32'h0F0F_0000, "R1 mask readback");
    wr(A_CTL, 32'h00FF_00FF);
    rd(A_CTL, 32'h00FF_00FF, "R1 ctl readback");
    wr(12'h018, 32'hFFFF_FFFF);
    wr(12'h002, 32'hFFFF_FFFF);
    rd(12'h018, 32'd0, "R1 unmapped read");
    rd(12'h002, 32'd0, "R1 misaligned read");
    rd(A_DIR, 32'h8000_0002, "R1 dir untouched");

    // R9: narrow accesses
    wr(A_DIR, 32'hFFFF_FFFF, 4'h3);
    chk("R9 pin_oe after narrow write", pin_oe, rev(32'h8000_0002));
    rd(A_DIR, 32'h8000_0002, "R9 dir after narrow write");
    rd(A_DIR, 32'd0, "R9 narrow read", 4'h1);

    // R6: any-change capture with latency
    wr(A_DIR, 32'd0);
    wr(A_MASK, 32'd0);
    wr(A_CTL, 32'd0);
    pin_in[5] = 1'b1;
    @(posedge clk); @(posedge clk);
    rd(A_EVT, 32'd0, "R6 not yet latched");
    rd(A_EVT, 32'h0400_0000, "R6 rise latched");
    rd(A_DATA, 32'hC400_0003, "R6 data follows rise");
    wr(A_EVT, 32'h0400_0000);
    rd(A_EVT, 32'd0, "R4 cleared");
    pin_in[5] = 1'b0;
    waitc(4);
    rd(A_EVT, 32'h0400_0000, "R6 fall latched");
    rd(A_DATA, 32'hC000_0003, "R6 data follows fall");
    wr(A_EVT, 32'h0400_0000);

    // R5 R4: interrupt and write-one-to-clear
    wr(A_MASK, 32'h0400_0000);
    chk("R5 irq idle", {31'd0, irq}, 32'd0);
    pin_in[5] = 1'b1;
    waitc(4);
    chk("R5 irq raised", {31'd0, irq}, 32'd1);
    wr(A_EVT, 32'd0);
    chk("R4 zero write keeps", {31'd0, irq}, 32'd1);
    wr(A_EVT, 32'hFBFF_FFFF);
    rd(A_EVT, 32'h0400_0000, "R4 other ones keep bit");
    wr(A_EVT, 32'h0400_0000);
    chk("R5 irq dropped after clear", {31'd0, irq}, 32'd0);
    pin_in[5] = 1'b0;
    waitc(4);
    chk("R5 irq on fall", {31'd0, irq}, 32'd1);
    wr(A_MASK, 32'd0);
    chk("R5 irq masked", {31'd0, irq}, 32'd0);
    rd(A_EVT, 32'h0400_0000, "R5 event still pending");
    wr(A_EVT, 32'hFFFF_FFFF);

    // R7: falling-only capture
    wr(A_CTL, 32'h0200_0000);
    pin_in[6] = 1'b1;
    waitc(4);
    rd(A_EVT, 32'd0, "R7 rise ignored");
    rd(A_DATA, 32'hC200_0003, "R7 data follows rise");
    pin_in[6] = 1'b0;
    waitc(4);
    rd(A_EVT, 32'h0200_0000, "R7 fall latched");
    wr(A_EVT, 32'hFFFF_FFFF);

    // R8: output pin ignores its input
    wr(A_DIR, 32'h0100_0000);
    pin_in[7] = 1'b1;
    waitc(4);
    rd(A_EVT, 32'd0, "R8 no event on output pin");
    rd(A_DATA, 32'hC000_0003, "R8 data unchanged");
    chk("R8 pin_out low", pin_out, 32'd0);
    wr(A_DATA, 32'hC100_0003);
    chk("R2 pin7 driven", pin_out, 32'h0000_0080);
    pin_in[7] = 1'b0;
    waitc(4);
    rd(A_DATA, 32'hC100_0003, "R8 data held");

    // R11: event and clear on the same edge
    @(negedge clk);
    pin_in[8] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(A_EVT, 32'h0080_0000);
    rd(A_EVT, 32'h0080_0000, "R11 set beats clear");

    repeat (4) @(negedge clk);
    chk("R12 all responses seen", exp_q.size(), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule